// File: doc/BRIEF.md
# Duty-Ratio Self-Clocked Bus Decoder

This block receives command words from a three-level bus (idle, signal-high, signal-low). Each bit is one low interval followed by one high interval. The value of the bit is set by which of the two intervals lasted longer. The block times both intervals with its local clock, so it does not need a known bit rate and accepts a wide range of data rates. The master usually drives a zero as about two thirds low and one third high, and a one the other way round.

The bus-level code comes from an external level detector, which already merges the two bus sides. A second input tells the block whether the signaling is arriving on the output side. A third input reports whether the device has already been initialized.

When a word ends, the block presents the word right-justified with its bit count and pulses a strobe for one clock. It also pulses a qualify signal with the strobe when the word could be taken as a reverse-initialization command. The output is a one-cycle valid pulse with no ready input, because the bus cannot be held off. The consumer must capture the word, count and qualify signal in the cycle the strobe is high. The outputs then hold until the next word replaces them.

Top module: `dr_bus_decoder`

## Requirements
- R1: After reset, rx_valid, rinit_ok, rx_word and rx_cnt are all zero.
- R2: The level code is 2'b00 idle, 2'b01 signal-high, 2'b10 signal-low, and 2'b11 is treated as idle. A word starts only when idle is followed by signal-high and then signal-low. Idle followed directly by signal-low starts nothing and produces no strobe.
- R3: A bit decodes as 1 when its high time, counted in clock cycles, is greater than its low time. Otherwise it decodes as 0, including when the two are equal.
- R4: Low and high times are counted by 12-bit counters that stop at 4095. When both intervals exceed 4095 cycles, the bit decodes as 0.
- R5: Bits shift in first-received as most significant. rx_word holds the received bits right-justified with zeros above them, and rx_cnt gives the number of bits.
- R6: A word ends when the bus goes from signal-high to idle. rx_valid is high for exactly the one cycle after the first sampled idle.
- R7: A return to idle during a low interval drops the word with no strobe. The next word is decoded from an empty register.
- R8: When a word has more than 16 bits, rx_word holds the last 16 bits received and rx_cnt stops at 16.
- R9: rinit_ok pulses together with rx_valid only if sig_on_out was high when the bus left idle for that word and dev_init was low when the word ended. Otherwise it stays low.
- R10: rx_word and rx_cnt change only in the cycle rx_valid is high, and they hold their values otherwise, including after a dropped word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used to time the intervals |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_lvl | input | 2 | Bus level code from the level detector |
| sig_on_out | input | 1 | High when the signaling is arriving on the output side |
| dev_init | input | 1 | High once the device has been initialized |
| rx_word | output | 16 | Last received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe at the end of a word |
| rx_cnt | output | 5 | Bit count of the last word |
| rinit_ok | output | 1 | Reverse-initialization qualify, valid with rx_valid |

## Verification
The hardest case to reach from the ports is counter saturation. The difference only shows when both intervals run past 4095 cycles, and the unsaturated comparison would have given the other answer. The stimulus holds one bit low for 4200 cycles and high for 5000 cycles, and expects a 0 where plain counting would give a 1. A word dropped in the middle of a low interval is the other hard case. The bench shows it by counting strobes, checking that the outputs held their old values, and then checking that a short word sent next has the right count.

// File: rtl/dr_bus_pkg.sv
package dr_bus_pkg;
  typedef enum logic [1:0] {
    LV_IDLE = 2'b00,
    LV_HIGH = 2'b01,
    LV_LOW  = 2'b10,
    LV_ALT  = 2'b11
  } bus_lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARM  = 2'b01,
    ST_LOW  = 2'b10,
    ST_HIGH = 2'b11
  } frame_st_e;

  typedef struct packed {
    logic arm;
    logic start;
    logic lo_load;
    logic lo_inc;
    logic hi_load;
    logic hi_inc;
    logic bit_done;
    logic word_end;
  } frame_ctl_t;
endpackage

// File: rtl/dr_sat_counter.sv
module dr_sat_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load_one) begin
      q <= ONE;
    end else if (inc && (q != MAXV)) begin
      q <= q + ONE;
    end
  end
endmodule

// File: rtl/dr_frame_fsm.sv
module dr_frame_fsm
  import dr_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_lvl,
  output frame_ctl_t ctl
);
  frame_st_e st_q, st_d;
  logic is_hi, is_lo, is_idle;

  assign is_hi   = (bus_lvl == LV_HIGH);
  assign is_lo   = (bus_lvl == LV_LOW);
  assign is_idle = (bus_lvl == LV_IDLE) || (bus_lvl == LV_ALT);

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    case (st_q)
      ST_IDLE: begin
        if (is_hi) begin
          st_d    = ST_ARM;
          ctl.arm = 1'b1;
        end
      end
      ST_ARM: begin
        if (is_lo) begin
          st_d        = ST_LOW;
          ctl.start   = 1'b1;
          ctl.lo_load = 1'b1;
        end else if (is_idle) begin
          st_d = ST_IDLE;
        end
      end
      ST_LOW: begin
        if (is_lo) begin
          ctl.lo_inc = 1'b1;
        end else if (is_hi) begin
          st_d        = ST_HIGH;
          ctl.hi_load = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_HIGH: begin
        if (is_hi) begin
          ctl.hi_inc = 1'b1;
        end else if (is_lo) begin
          st_d         = ST_LOW;
          ctl.bit_done = 1'b1;
          ctl.lo_load  = 1'b1;
        end else begin
          st_d         = ST_IDLE;
          ctl.bit_done = 1'b1;
          ctl.word_end = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/dr_bit_shifter.sv
module dr_bit_shifter #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] sh_nxt,
  output logic [CNT_W-1:0]  cnt_nxt
);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  generate
    if (WORD_W > 1) begin : g_wide
      assign sh_nxt = {sh_q[WORD_W-2:0], bit_in};
    end else begin : g_one
      assign sh_nxt = bit_in;
    end
  endgenerate

  assign cnt_nxt = (cnt_q == CMAX) ? cnt_q : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q  <= sh_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/dr_bus_decoder.sv
module dr_bus_decoder
  import dr_bus_pkg::*;
#(
  parameter int DUR_W  = 12,
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_lvl,
  input  logic              sig_on_out,
  input  logic              dev_init,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic              rinit_ok
);
  frame_ctl_t        ctl;
  logic [DUR_W-1:0]  lo_time, hi_time;
  logic              bit_val;
  logic [WORD_W-1:0] sh_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              side_q;

  dr_frame_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_lvl (bus_lvl),
    .ctl     (ctl)
  );

  dr_sat_counter #(.W(DUR_W)) u_lo_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_one (ctl.lo_load),
    .inc      (ctl.lo_inc),
    .q        (lo_time)
  );

  dr_sat_counter #(.W(DUR_W)) u_hi_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_one (ctl.hi_load),
    .inc      (ctl.hi_inc),
    .q        (hi_time)
  );

  // the interval just ending is already complete in the counters
  assign bit_val = (hi_time > lo_time);

  dr_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ctl.start),
    .shift_en (ctl.bit_done),
    .bit_in   (bit_val),
    .sh_nxt   (sh_nxt),
    .cnt_nxt  (cnt_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q   <= 1'b0;
      rx_word  <= '0;
      rx_cnt   <= '0;
      rx_valid <= 1'b0;
      rinit_ok <= 1'b0;
    end else begin
      if (ctl.arm) side_q <= sig_on_out;
      rx_valid <= ctl.word_end;
      rinit_ok <= ctl.word_end && side_q && !dev_init;
      if (ctl.word_end) begin
        rx_word <= sh_nxt;
        rx_cnt  <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/dr_bus_decoder_chk.sv
module dr_bus_decoder_chk #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_lvl,
  input logic              dev_init,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              rinit_ok
);
  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  valid_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(bus_lvl) == 2'b00 || $past(bus_lvl) == 2'b11));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(WORD_W));

  // R5
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_cnt != '0));

  // R9
  rinit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rinit_ok |-> (rx_valid && !$past(dev_init)));

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_word) && $stable(rx_cnt)));
endmodule

bind dr_bus_decoder dr_bus_decoder_chk #(.WORD_W(WORD_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_lvl  (bus_lvl),
  .dev_init (dev_init),
  .rx_word  (rx_word),
  .rx_valid (rx_valid),
  .rx_cnt   (rx_cnt),
  .rinit_ok (rinit_ok)
);

// File: tb/dr_bus_decoder_tb_top.sv
module dr_bus_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_lvl = 2'b00;
  logic        sig_on_out = 1'b0;
  logic        dev_init = 1'b0;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic [4:0]  rx_cnt;
  logic        rinit_ok;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dr_bus_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_lvl(bus_lvl), .sig_on_out(sig_on_out),
    .dev_init(dev_init), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_cnt(rx_cnt), .rinit_ok(rinit_ok)
  );

  always @(posedge clk) if (rx_valid) pulses <= pulses + 1;

  // fields: nbits[38:34] bits[33:18] short[17:10] long[9:2] side[1] init[0]
  localparam int NV = 7;
  localparam logic [38:0] VEC [0:NV-1] = '{
    {5'd8,  16'h00A5, 8'd1,  8'd2,  1'b0, 1'b0},
    {5'd16, 16'h1234, 8'd3,  8'd6,  1'b1, 1'b0},
    {5'd16, 16'hFFFF, 8'd1,  8'd2,  1'b1, 1'b1},
    {5'd1,  16'h0001, 8'd5,  8'd10, 1'b0, 1'b0},
    {5'd12, 16'h0800, 8'd2,  8'd3,  1'b1, 1'b0},
    {5'd16, 16'h0000, 8'd4,  8'd9,  1'b0, 1'b1},
    {5'd5,  16'h0015, 8'd10, 8'd20, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input int n);
    bus_lvl = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input int lo, input int hi);
    drive(2'b10, lo);
    drive(2'b01, hi);
  endtask

  task automatic frame_open(input logic side, input logic init);
    sig_on_out = side;
    dev_init = init;
    drive(2'b00, 3);
    drive(2'b01, 2);
  endtask

  task automatic send_word(input int nb, input logic [31:0] bits, input int sh,
                           input int lg, input logic [1:0] endc);
    for (int i = nb - 1; i >= 0; i--) begin
      if (bits[i]) send_bit(sh, lg);
      else         send_bit(lg, sh);
    end
    bus_lvl = endc;
    @(negedge clk);
  endtask

  task automatic expect_word(input string req, input logic [15:0] w,
                             input logic [4:0] c, input logic ri);
    check({req, " valid"}, 32'(rx_valid), 32'd1);
    check({req, " word"}, 32'(rx_word), 32'(w));
    check({req, " count"}, 32'(rx_cnt), 32'(c));
    check({req, " rinit"}, 32'(rinit_ok), 32'(ri));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    logic [15:0] w;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(rx_valid), 0);
    check("R1 word", 32'(rx_word), 0);
    check("R1 count", 32'(rx_cnt), 0);
    check("R1 rinit", 32'(rinit_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R5 R6 R9 table of words
    for (int k = 0; k < NV; k++) begin
      logic [38:0] v;
      logic [15:0] m;
      v = VEC[k];
      m = (v[38:34] >= 5'd16) ? 16'hFFFF : 16'((32'd1 << v[38:34]) - 1);
      p0 = pulses;
      frame_open(v[1], v[0]);
      send_word(int'(v[38:34]), 32'(v[33:18]), int'(v[17:10]), int'(v[9:2]), 2'b00);
      expect_word("R5 R9 table", v[33:18] & m, v[38:34], v[1] & ~v[0]);
      drive(2'b00, 2);
      check("R6 one pulse", 32'(pulses - p0), 1);
    end

    // R3 equal lengths decode as 0, one longer high decodes as 1
    frame_open(1'b0, 1'b0);
    send_bit(3, 3); send_bit(3, 3); send_bit(3, 3); send_bit(3, 4);
    bus_lvl = 2'b00; @(negedge clk);
    expect_word("R3 equal", 16'h0001, 5'd4, 1'b0);
    drive(2'b00, 2);

    // R4 both intervals saturate -> 0
    frame_open(1'b0, 1'b0);
    send_bit(4200, 5000);
    send_bit(2, 4);
    bus_lvl = 2'b00; @(negedge clk);
    expect_word("R4 saturate", 16'h0001, 5'd2, 1'b0);
    drive(2'b00, 2);

    // R2 code 11 ends a word like idle
    frame_open(1'b1, 1'b0);
    send_word(4, 32'hA, 2, 5, 2'b11);
    expect_word("R2 alt idle", 16'h000A, 5'd4, 1'b1);
    drive(2'b00, 2);

    // R8 overlong word keeps last 16 bits
    frame_open(1'b0, 1'b0);
    send_word(18, 32'h2ABCD, 1, 3, 2'b00);
    expect_word("R8 overflow", 16'hABCD, 5'd16, 1'b0);
    drive(2'b00, 2);
    w = rx_word;

    // R7 R10 abort during low
    p0 = pulses;
    frame_open(1'b1, 1'b0);
    send_bit(2, 5); send_bit(5, 2);
    drive(2'b10, 3);
    drive(2'b00, 5);
    check("R7 no pulse on abort", 32'(pulses - p0), 0);
    check("R10 word held", 32'(rx_word), 32'(w));
    check("R10 count held", 32'(rx_cnt), 16);
    frame_open(1'b0, 1'b0);
    send_word(4, 32'h9, 2, 4, 2'b00);
    expect_word("R7 fresh word", 16'h0009, 5'd4, 1'b0);
    drive(2'b00, 2);

    // R2 idle straight to low starts nothing
    p0 = pulses;
    drive(2'b10, 6);
    drive(2'b00, 4);
    check("R2 no start", 32'(pulses - p0), 0);
    check("R2 count held", 32'(rx_cnt), 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule